// File: doc/BRIEF.md
# Flash Bank Power State Controller

This block decides the power state of a single flash bank. The state is one of sleep, standby or active. The bank leaves reset asleep. When a read or fetch request arrives while the bank is not active, the block walks it up to active through fixed wake-up phases. The requester sees its ready signal held low for the whole wake-up, so it is stalled with no extra logic on its side. Once the bank is active, requests complete in the same cycle they are presented.

After each completed access, a reloadable grace counter keeps the bank active for a programmed number of idle cycles. When the counter runs out, the bank drops to a fallback state chosen by software. The fallback can be active, which pins the bank on. The current state is published as a registered code so that a neighbouring pump controller can decode it.

Top module: `flash_bank_pwr_ctrl`

## Requirements
- R1: `pwr_mode_o` encodes sleep as 0, standby as 1 and active as 2. `fallback_i` uses the same codes, and its code 3 is treated as active.
- R2: While `rst` is high and in the cycle after it, `pwr_mode_o` is 0 and `acc_rdy_o` is low when no request is driven.
- R3: A request first presented in cycle 0 while the bank sleeps keeps `pwr_mode_o` at 0 through cycle 8 and at 1 through cycle 12. It shows 2 and raises `acc_rdy_o` in cycle 13 (8 wake cycles to standby, 4 more to active). The bank never goes from sleep to active in one step.
- R4: A request first presented in cycle 0 while the bank is in standby raises `acc_rdy_o` and shows mode 2 in cycle 5.
- R5: `acc_rdy_o` is high exactly in cycles where `acc_req_i` is high and `pwr_mode_o` is 2.
- R6: An access completes in cycle t with grace value G > 0 and a fallback of sleep or standby. With no further request, the bank stays active in cycles t+1 to t+G and shows the fallback code from cycle t+G+1.
- R7: A grace value of 0 makes `pwr_mode_o` show the fallback code in cycle t+1, the cycle right after the access completes.
- R8: Each completed access restarts the grace count from the value programmed at that time.
- R9: With the fallback set to active (code 2 or 3), the bank remains active for any number of idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req_i | input | 1 | Read/fetch request, held until ready |
| acc_rdy_o | output | 1 | Access completes in a cycle where request and ready are both high |
| grace_i | input | GRACE_W | Idle cycles the bank stays active after an access |
| fallback_i | input | 2 | Power state to take when the grace count runs out |
| pwr_mode_o | output | 2 | Registered current power state code |

## Verification
The hardest case to reach from the ports is the grace counter boundary: the last active idle cycle against the first fallback cycle, and a new access landing inside a running count. Seen from outside, a reload looks the same as a stale counter unless the sample falls between the two possible expiry points. The stimulus holds a request until ready, then waits a counted number of idle cycles from the completing cycle before sampling. Table entries sit one cycle either side of expiry, and a directed case issues a second access mid-grace and samples in the window where only a reloaded count still reads active.

// File: rtl/fbpc_pkg.sv
package fbpc_pkg;

  typedef enum logic [1:0] {
    PM_SLEEP  = 2'd0,
    PM_STBY   = 2'd1,
    PM_ACTIVE = 2'd2
  } pmode_e;

  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_TO_STBY,
    ST_STBY,
    ST_TO_ACT,
    ST_ACTIVE
  } bstate_e;

  function automatic logic [1:0] mode_of(bstate_e s);
    case (s)
      ST_SLEEP, ST_TO_STBY: return PM_SLEEP;
      ST_STBY, ST_TO_ACT:   return PM_STBY;
      default:              return PM_ACTIVE;
    endcase
  endfunction

  function automatic logic keeps_active(logic [1:0] fb);
    return fb[1];
  endfunction

endpackage

// File: rtl/fbpc_down_cnt.sv
module fbpc_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (dec_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R6: the controller only steps a counter that still has cycles left
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !load_i) |-> !zero_o);

endmodule

// File: rtl/flash_bank_pwr_ctrl.sv
module flash_bank_pwr_ctrl
  import fbpc_pkg::*;
#(
  parameter int GRACE_W      = 8,
  parameter int SB_WAKE_CYC  = 8,
  parameter int ACT_WAKE_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_req_i,
  output logic               acc_rdy_o,
  input  logic [GRACE_W-1:0] grace_i,
  input  logic [1:0]         fallback_i,
  output logic [1:0]         pwr_mode_o
);

  localparam int WAKE_MAX = (SB_WAKE_CYC > ACT_WAKE_CYC) ? SB_WAKE_CYC : ACT_WAKE_CYC;
  localparam int WCW      = $clog2(WAKE_MAX + 1);
  localparam logic [WCW-1:0] SB_LOAD  = WCW'(SB_WAKE_CYC - 1);
  localparam logic [WCW-1:0] ACT_LOAD = WCW'(ACT_WAKE_CYC - 1);

  bstate_e state_q, state_d;
  logic [1:0] mode_q;

  logic           wake_load, wake_dec, wake_zero;
  logic [WCW-1:0] wake_val;
  logic           grace_load, grace_dec, grace_zero;
  logic [GRACE_W-1:0] grace_val;
  logic           fb_on;
  bstate_e        fb_state;

  assign fb_on     = keeps_active(fallback_i);
  assign fb_state  = (fallback_i == PM_STBY) ? ST_STBY : ST_SLEEP;
  assign grace_val = (grace_i == '0) ? '0 : grace_i - 1'b1;

  fbpc_down_cnt #(.W(WCW)) wake_cnt_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (wake_load),
    .load_val_i (wake_val),
    .dec_i      (wake_dec),
    .zero_o     (wake_zero)
  );

  fbpc_down_cnt #(.W(GRACE_W)) grace_cnt_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (grace_load),
    .load_val_i (grace_val),
    .dec_i      (grace_dec),
    .zero_o     (grace_zero)
  );

  always_comb begin
    state_d    = state_q;
    wake_load  = 1'b0;
    wake_val   = SB_LOAD;
    wake_dec   = 1'b0;
    grace_load = 1'b0;
    grace_dec  = 1'b0;
    case (state_q)
      ST_SLEEP: begin
        if (acc_req_i) begin
          state_d   = ST_TO_STBY;
          wake_load = 1'b1;
          wake_val  = SB_LOAD;
        end
      end
      ST_TO_STBY: begin
        if (wake_zero) begin
          state_d   = ST_TO_ACT;
          wake_load = 1'b1;
          wake_val  = ACT_LOAD;
        end else begin
          wake_dec = 1'b1;
        end
      end
      ST_STBY: begin
        if (acc_req_i) begin
          state_d   = ST_TO_ACT;
          wake_load = 1'b1;
          wake_val  = ACT_LOAD;
        end
      end
      ST_TO_ACT: begin
        if (wake_zero) begin
          state_d    = ST_ACTIVE;
          grace_load = 1'b1;
        end else begin
          wake_dec = 1'b1;
        end
      end
      default: begin
        if (acc_req_i) begin
          if (!fb_on && grace_i == '0) begin
            state_d = fb_state;
          end else begin
            grace_load = 1'b1;
          end
        end else if (!fb_on) begin
          if (grace_zero) begin
            state_d = fb_state;
          end else begin
            grace_dec = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SLEEP;
      mode_q  <= PM_SLEEP;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_of(state_d);
    end
  end

  assign pwr_mode_o = mode_q;
  assign acc_rdy_o  = acc_req_i && (state_q == ST_ACTIVE);

  // R2: reset leaves the bank asleep
  assert_reset_sleep_R2: assert property (@(posedge clk)
    rst |=> (pwr_mode_o == PM_SLEEP));

  // R3: sleep never jumps straight to active
  assert_no_skip_wake_R3: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode_o == PM_SLEEP) |=> (pwr_mode_o != PM_ACTIVE));

  // R5: ready only while the bank is active
  assert_rdy_active_R5: assert property (@(posedge clk) disable iff (rst)
    acc_rdy_o |-> (pwr_mode_o == PM_ACTIVE));

  // R6: a completed access with non-zero grace keeps the bank active next cycle
  assert_grace_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_rdy_o && grace_i != '0) |=> (pwr_mode_o == PM_ACTIVE));

  // R9: an active fallback never lets the bank leave active
  assert_pinned_active_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode_o == PM_ACTIVE && fallback_i[1]) |=> (pwr_mode_o == PM_ACTIVE));

endmodule

// File: tb/flash_bank_pwr_ctrl_tb_top.sv
module flash_bank_pwr_ctrl_tb_top;

  localparam int SB  = 8;
  localparam int ACT = 4;
  localparam int WD  = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       rdy;
  logic [7:0] grace = 8'd0;
  logic [1:0] fb = 2'd2;
  logic [1:0] mode;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  flash_bank_pwr_ctrl #(.GRACE_W(8), .SB_WAKE_CYC(SB), .ACT_WAKE_CYC(ACT)) dut_i (
    .clk(clk), .rst(rst), .acc_req_i(req), .acc_rdy_o(rdy),
    .grace_i(grace), .fallback_i(fb), .pwr_mode_o(mode)
  );

  // fields: fallback[19:18] grace[17:10] idle[9:2] expected_mode[1:0]
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 8'd3,  8'd0,  2'd2},
    {2'd1, 8'd3,  8'd2,  2'd2},
    {2'd1, 8'd3,  8'd3,  2'd1},
    {2'd0, 8'd5,  8'd5,  2'd0},
    {2'd0, 8'd0,  8'd0,  2'd0},
    {2'd2, 8'd0,  8'd40, 2'd2},
    {2'd3, 8'd1,  8'd30, 2'd2},
    {2'd1, 8'd0,  8'd0,  2'd1},
    {2'd0, 8'd10, 8'd9,  2'd2},
    {2'd0, 8'd10, 8'd10, 2'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <= %0d cycles", cyc, WD);
      summary();
      $finish;
    end
  end

  // Presents one access, checks the stall against the mode seen at request time.
  task automatic do_access(input logic [1:0] f, input logic [7:0] g);
    int n;
    int exp_stall;
    @(negedge clk);
    fb = f; grace = g; req = 1'b1;
    #1;
    exp_stall = (mode == 2'd0) ? 1 + SB + ACT : (mode == 2'd1) ? 1 + ACT : 0;
    n = 0;
    while (!rdy && n < 60) begin
      @(negedge clk); #1; n++;
    end
    chk("R3/R4 stall cycles", n, exp_stall);
    chk("R5 ready with active mode", mode, 2);
    @(negedge clk);
    req = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R2 reset mode", mode, 0);
    chk("R2 reset ready", rdy, 0);
    @(negedge clk); rst = 1'b0; #1;
    chk("R2 mode after reset", mode, 0);

    // R3: cycle-by-cycle wake from sleep
    @(negedge clk);
    fb = 2'd1; grace = 8'd3; req = 1'b1;
    #1;
    for (int i = 0; i <= 1 + SB + ACT - 1 + 1; i++) begin
      if (i > 0) begin @(negedge clk); #1; end
      chk("R3 wake mode", mode, (i <= SB) ? 0 : (i <= SB + ACT) ? 1 : 2);
      chk("R3/R5 ready during wake", rdy, (i == 1 + SB + ACT) ? 1 : 0);
    end
    @(negedge clk); req = 1'b0; #1;

    // table walk: access, then idle gap, then expected mode
    for (int v = 0; v < NV; v++) begin
      do_access(VEC[v][19:18], VEC[v][17:10]);
      repeat (int'(VEC[v][9:2])) @(negedge clk);
      #1;
      chk($sformatf("R6/R7/R9 vec %0d mode", v), mode, int'(VEC[v][1:0]));
      chk("R5 no ready when idle", rdy, 0);
    end

    // R8: access in the middle of the grace period reloads the count
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0; #1;
    chk("R2 mode after mid-run reset", mode, 0);
    do_access(2'd1, 8'd4);
    do_access(2'd1, 8'd4);
    repeat (3) @(negedge clk);
    #1;
    chk("R8 still active after reload", mode, 2);
    @(negedge clk); #1;
    chk("R8 fallback after reloaded grace", mode, 1);

    // R4: short wake from standby, then R1 code 3 pinned active
    do_access(2'd3, 8'd0);
    repeat (20) @(negedge clk);
    #1;
    chk("R1 code 3 acts as active", mode, 2);

    summary();
    $finish;
  end

endmodule